// File: doc/BRIEF.md
# Filtered Receive Message FIFO

This block keeps a small ring of message buffers between a receiver and a host. Incoming messages arrive on a parallel interface carrying a valid strobe, an 8-bit identifier, a 4-bit length and twelve data bytes. Each one first goes through an identifier filter built from two pattern/mask pairs. One pair says which identifiers may be taken. The other says which identifiers must be turned away, and when both pairs match, the message is turned away. A message that survives the filter is written into the buffer at the put index, and the put index then advances around the ring.

The host reads with a level lock request. When the lock rises, the buffer at the get index is shown on a read window. When the lock falls, the get index steps forward one slot. A full ring and an empty ring both have equal indices. The block tells them apart by which index moved last. A message that arrives while the ring is full is lost and raises a sticky overrun flag, which the host clears by writing a one.

Top module: `rxq_filtered_fifo`

## Requirements
- R1: After reset the ring is empty (`fifo_empty`=1, `fifo_full`=0), `fifo_overrun` is 0 and the window is invalid.
- R2: Stored messages are returned through the window in arrival order, with identifier, length and data bits all intact.
- R3: After `NBUF` stored messages with no reads, `fifo_full` is 1 and `fifo_empty` is 0; `fifo_full` and `fifo_empty` are never both 1.
- R4: A message that passes the filter while the ring is full is discarded, sets `fifo_overrun` on the next clock, and leaves the stored contents unchanged.
- R5: `fifo_overrun` stays set until `ovr_clr` is driven 1 for a cycle; a new overrun in the clearing cycle wins.
- R6: One clock after `host_lock` rises on a non-empty ring, `win_valid` is 1 and the window shows the buffer at the get index. This window stays unchanged while `host_lock` stays 1.
- R7: A fall of `host_lock` that follows a valid window advances the get index by one, modulo `NBUF`, so reading every stored message leaves the ring empty.
- R8: A message passes acceptance when, for every bit where `acc_dc` is 0, the identifier bit equals `acc_pat`; bits where `acc_dc` is 1 are ignored.
- R9: A message hits rejection when, for every bit where `rej_dc` is 0, the identifier bit equals `rej_pat`; a message that hits rejection is never stored, even if it passes acceptance.
- R10: A message turned away by the filter changes neither index, `fifo_empty`, `fifo_full` nor `fifo_overrun`, even when the ring is full.
- R11: A lock raised while the ring is empty gives `win_valid`=0 with all window fields 0, and its unlock does not move the get index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming message strobe, one cycle per message |
| in_id | input | 8 | Incoming identifier |
| in_len | input | 4 | Incoming length field |
| in_data | input | 96 | Incoming data bytes |
| acc_pat | input | 8 | Acceptance pattern |
| acc_dc | input | 8 | Acceptance don't-care mask (1 = ignore bit) |
| rej_pat | input | 8 | Rejection pattern |
| rej_dc | input | 8 | Rejection don't-care mask (1 = ignore bit) |
| host_lock | input | 1 | Host lock request, level |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| win_valid | output | 1 | Read window holds a stored message |
| win_id | output | 8 | Window identifier |
| win_len | output | 4 | Window length |
| win_data | output | 96 | Window data |
| fifo_empty | output | 1 | Ring holds no message |
| fifo_full | output | 1 | Ring holds NBUF messages |
| fifo_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sweeps all 256 identifiers through two filter setups. One setup has a rejection region nested inside the acceptance region, so a design that let acceptance override rejection would store identifiers it must drop. The bench fills the ring to the brim and then offers both a passing message and a filtered message. A design that judged full and empty by index equality alone would report empty, and one that let filtered traffic reach the overrun logic would set the flag. It also locks an empty ring and then checks that the next real message is still read first. It then drives the indices around the ring several times, which exposes wrap-around and ordering faults.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ID_W      = 8;
    localparam int LEN_W     = 4;
    localparam int MAX_BYTES = 12;
    localparam int DATA_W    = MAX_BYTES * 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } msg_t;
endpackage

// File: rtl/rxq_filter.sv
module rxq_filter
    import rxq_pkg::*;
(
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] acc_pat,
    input  logic [ID_W-1:0] acc_dc,
    input  logic [ID_W-1:0] rej_pat,
    input  logic [ID_W-1:0] rej_dc,
    output logic            acc_hit,
    output logic            rej_hit,
    output logic            pass
);
    logic [ID_W-1:0] acc_bit;
    logic [ID_W-1:0] rej_bit;

    for (genvar b = 0; b < ID_W; b++) begin : g_bit
        // a bit agrees when it is ignored or equal to the pattern
        assign acc_bit[b] = acc_dc[b] | (id[b] ~^ acc_pat[b]);
        assign rej_bit[b] = rej_dc[b] | (id[b] ~^ rej_pat[b]);
    end

    assign acc_hit = &acc_bit;
    assign rej_hit = &rej_bit;
    // rejection overrides acceptance
    assign pass    = acc_hit & ~rej_hit;
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int NBUF  = 3,
    parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic [IDX_W-1:0] put_idx,
    output logic [IDX_W-1:0] get_idx,
    output logic             wr_en,
    output logic             empty,
    output logic             full,
    output logic             overrun
);
    typedef struct packed {
        logic [IDX_W-1:0] put;
        logic [IDX_W-1:0] get;
        logic             put_last;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_q, st_d;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(NBUF - 1)) ? '0 : v + 1'b1;
    endfunction

    assign put_idx = st_q.put;
    assign get_idx = st_q.get;
    assign empty   = (st_q.put == st_q.get) && !st_q.put_last;
    assign full    = (st_q.put == st_q.get) &&  st_q.put_last;
    assign overrun = st_q.ovr;
    assign wr_en   = push_req && !full;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.put = step(st_q.put);
        if (pop)   st_d.get = step(st_q.get);
        if (wr_en && !pop)      st_d.put_last = 1'b1;
        else if (pop && !wr_en) st_d.put_last = 1'b0;
        if (ovr_clr)            st_d.ovr = 1'b0;
        if (push_req && full)   st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> overrun);
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rxq_lock.sv
module rxq_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic host_lock,
    input  logic empty,
    output logic locked,
    output logic show,
    output logic pop
);
    typedef struct packed {
        logic lock;
        logic has;
    } lock_t;

    lock_t lk_q, lk_d;

    assign locked = lk_q.lock;
    assign show   = lk_q.lock && lk_q.has;

    always_comb begin
        lk_d = lk_q;
        pop  = 1'b0;
        if (host_lock && !lk_q.lock) begin
            lk_d.lock = 1'b1;
            lk_d.has  = !empty;   // an empty ring yields a void window
        end else if (!host_lock && lk_q.lock) begin
            lk_d.lock = 1'b0;
            lk_d.has  = 1'b0;
            pop       = lk_q.has; // only a real read advances
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    p_empty_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_lock && !locked && empty) |=> !show);
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && host_lock) |=> $stable(show));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int NBUF  = 3,
    parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  msg_t             wr_msg,
    input  logic [IDX_W-1:0] rd_idx,
    output msg_t             rd_msg
);
    msg_t slot_q [NBUF];
    msg_t slot_d [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) slot_d[g] = wr_msg;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
    end

    assign rd_msg = (int'(rd_idx) < NBUF) ? slot_q[rd_idx] : '0;

    p_wr_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NBUF));
endmodule

// File: rtl/rxq_filtered_fifo.sv
module rxq_filtered_fifo
    import rxq_pkg::*;
#(
    parameter int NBUF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_id,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ID_W-1:0]   acc_pat,
    input  logic [ID_W-1:0]   acc_dc,
    input  logic [ID_W-1:0]   rej_pat,
    input  logic [ID_W-1:0]   rej_dc,
    input  logic              host_lock,
    input  logic              ovr_clr,
    output logic              win_valid,
    output logic [ID_W-1:0]   win_id,
    output logic [LEN_W-1:0]  win_len,
    output logic [DATA_W-1:0] win_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_overrun
);
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;

    logic             acc_hit, rej_hit, pass;
    logic             push_req, pop, wr_en, locked, show;
    logic [IDX_W-1:0] put_idx, get_idx;
    msg_t             in_msg, rd_msg;

    assign in_msg   = '{id: in_id, len: in_len, data: in_data};
    assign push_req = in_valid && pass;

    rxq_filter u_filter (
        .id(in_id), .acc_pat(acc_pat), .acc_dc(acc_dc),
        .rej_pat(rej_pat), .rej_dc(rej_dc),
        .acc_hit(acc_hit), .rej_hit(rej_hit), .pass(pass)
    );

    rxq_ctrl #(.NBUF(NBUF), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop(pop),
        .ovr_clr(ovr_clr), .put_idx(put_idx), .get_idx(get_idx),
        .wr_en(wr_en), .empty(fifo_empty), .full(fifo_full),
        .overrun(fifo_overrun)
    );

    rxq_lock u_lock (
        .clk(clk), .rst_n(rst_n), .host_lock(host_lock),
        .empty(fifo_empty), .locked(locked), .show(show), .pop(pop)
    );

    rxq_store #(.NBUF(NBUF), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(put_idx),
        .wr_msg(in_msg), .rd_idx(get_idx), .rd_msg(rd_msg)
    );

    assign win_valid = show;
    assign win_id    = show ? rd_msg.id   : '0;
    assign win_len   = show ? rd_msg.len  : '0;
    assign win_data  = show ? rd_msg.data : '0;

    p_reject_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rej_hit) |-> !wr_en);
    p_drop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pass && !pop && !ovr_clr) |=>
            ($stable(fifo_empty) && $stable(fifo_full) && $stable(fifo_overrun)));
    p_window_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && host_lock && !in_valid) |=> $stable(win_id));
endmodule

// File: tb/tb_rxq_filtered_fifo.sv
`timescale 1ns/1ps
module tb_rxq_filtered_fifo;
    import rxq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ID_W-1:0]   in_id = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [ID_W-1:0]   acc_pat = '0, acc_dc = '1, rej_pat = '1, rej_dc = '0;
    logic              host_lock = 1'b0, ovr_clr = 1'b0;
    logic              win_valid, fifo_empty, fifo_full, fifo_overrun;
    logic [ID_W-1:0]   win_id;
    logic [LEN_W-1:0]  win_len;
    logic [DATA_W-1:0] win_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] q_id[$];
    logic [3:0] q_len[$];
    logic [7:0] q_seed[$];

    always #5 clk = ~clk;

    rxq_filtered_fifo dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
        .in_len(in_len), .in_data(in_data), .acc_pat(acc_pat), .acc_dc(acc_dc),
        .rej_pat(rej_pat), .rej_dc(rej_dc), .host_lock(host_lock),
        .ovr_clr(ovr_clr), .win_valid(win_valid), .win_id(win_id),
        .win_len(win_len), .win_data(win_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_overrun(fifo_overrun)
    );

    function automatic logic [DATA_W-1:0] mkdata(input logic [7:0] seed);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < MAX_BYTES; k++) d[k*8 +: 8] = seed + 8'(k * 29 + 1);
        return d;
    endfunction

    function automatic bit acc_f(input logic [7:0] id);
        return ((id ^ acc_pat) & ~acc_dc) == 8'h00;
    endfunction

    function automatic bit rej_f(input logic [7:0] id);
        return ((id ^ rej_pat) & ~rej_dc) == 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] id, input logic [3:0] len,
                        input logic [7:0] seed);
        @(negedge clk);
        in_valid = 1'b1; in_id = id; in_len = len; in_data = mkdata(seed);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // lock, compare the window with the oldest queued message, unlock
    task automatic read_one(input string tag);
        logic [7:0] eid, es;
        logic [3:0] el;
        eid = q_id.pop_front(); el = q_len.pop_front(); es = q_seed.pop_front();
        @(negedge clk);
        host_lock = 1'b1;
        @(negedge clk);
        chk(win_valid == 1'b1, {tag, " win_valid"}, 128'(win_valid), 128'(1));
        chk(win_id == eid, {tag, " win_id"}, 128'(win_id), 128'(eid));
        chk(win_len == el, {tag, " win_len"}, 128'(win_len), 128'(el));
        chk(win_data == mkdata(es), {tag, " win_data"}, 128'(win_data), 128'(mkdata(es)));
        @(negedge clk);
        chk(win_id == eid, {tag, " R6 window held"}, 128'(win_id), 128'(eid));
        host_lock = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] id, input logic [3:0] len,
                            input logic [7:0] seed);
        send(id, len, seed);
        q_id.push_back(id); q_len.push_back(len); q_seed.push_back(seed);
    endtask

    task automatic sweep(input string cfg);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] id;
            bit p;
            string tag;
            id  = 8'(i);
            p   = acc_f(id) && !rej_f(id);
            tag = rej_f(id) ? "R9" : "R8";
            send(id, 4'(i), 8'(i * 3));
            chk(fifo_empty == !p, {tag, " sweep ", cfg, " stored"},
                128'(fifo_empty), 128'(!p));
            if (p) begin
                q_id.push_back(id); q_len.push_back(4'(i)); q_seed.push_back(8'(i * 3));
                read_one({tag, " sweep ", cfg});
                chk(fifo_empty == 1'b1, "R7 sweep drain", 128'(fifo_empty), 128'(1));
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fifo_empty == 1'b1, "R1 empty", 128'(fifo_empty), 128'(1));
        chk(fifo_full == 1'b0, "R1 full", 128'(fifo_full), 128'(0));
        chk(fifo_overrun == 1'b0, "R1 overrun", 128'(fifo_overrun), 128'(0));
        chk(win_valid == 1'b0, "R1 window", 128'(win_valid), 128'(0));

        // accept everything except identifier FF
        acc_dc = 8'hFF; rej_pat = 8'hFF; rej_dc = 8'h00;

        // R11 lock on an empty ring
        @(negedge clk); host_lock = 1'b1;
        @(negedge clk);
        chk(win_valid == 1'b0, "R11 void window", 128'(win_valid), 128'(0));
        chk(win_id == 8'h00 && win_data == '0, "R11 window zero", 128'(win_id), 128'(0));
        host_lock = 1'b0;
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R11 still empty", 128'(fifo_empty), 128'(1));
        push_exp(8'h11, 4'd5, 8'h01);
        read_one("R11 first read after void lock");
        chk(fifo_empty == 1'b1, "R11 empty after", 128'(fifo_empty), 128'(1));

        // R3 fill
        for (int n = 0; n < 3; n++) begin
            push_exp(8'(8'h21 + n), 4'(n + 1), 8'(8'h30 + n));
            chk(fifo_empty == 1'b0, "R3 not empty", 128'(fifo_empty), 128'(0));
            chk(fifo_full == (n == 2), "R3 full flag", 128'(fifo_full), 128'(n == 2));
        end
        // R4 overrun on a full ring
        send(8'h24, 4'd9, 8'h77);
        chk(fifo_overrun == 1'b1, "R4 overrun set", 128'(fifo_overrun), 128'(1));
        chk(fifo_full == 1'b1, "R4 still full", 128'(fifo_full), 128'(1));
        // R5 clear
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk(fifo_overrun == 1'b0, "R5 cleared", 128'(fifo_overrun), 128'(0));
        // R10 filtered message on a full ring
        send(8'hFF, 4'd2, 8'h55);
        chk(fifo_overrun == 1'b0, "R10 no overrun", 128'(fifo_overrun), 128'(0));
        chk(fifo_full == 1'b1, "R10 still full", 128'(fifo_full), 128'(1));
        send(8'h25, 4'd3, 8'h66);
        chk(fifo_overrun == 1'b1, "R4 overrun again", 128'(fifo_overrun), 128'(1));
        // R2 order, R4 lost messages absent
        for (int n = 0; n < 3; n++) read_one("R2 order after overrun");
        chk(fifo_empty == 1'b1, "R7 drained", 128'(fifo_empty), 128'(1));
        chk(fifo_overrun == 1'b1, "R5 sticky", 128'(fifo_overrun), 128'(1));
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk(fifo_overrun == 1'b0, "R5 cleared again", 128'(fifo_overrun), 128'(0));

        // R7 wrap: indices walk around the ring several times
        for (int r = 0; r < 5; r++) begin
            push_exp(8'(8'h40 + 2 * r), 4'(r), 8'(8'h90 + r));
            push_exp(8'(8'h41 + 2 * r), 4'(r + 7), 8'(8'hA0 + r));
            read_one("R7 wrap");
            read_one("R7 wrap");
            chk(fifo_empty == 1'b1, "R7 wrap empty", 128'(fifo_empty), 128'(1));
        end

        // R8/R9 sweeps: rejection nested inside acceptance
        acc_pat = 8'hA5; acc_dc = 8'h0F; rej_pat = 8'hA0; rej_dc = 8'h03;
        sweep("nested");
        acc_pat = 8'h00; acc_dc = 8'hFF; rej_pat = 8'h80; rej_dc = 8'h7F;
        sweep("top-bit");
        chk(fifo_overrun == 1'b0, "R10 no overrun after sweeps", 128'(fifo_overrun), 128'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule